// File: doc/BRIEF.md
# Floating-Point Status and Rounding Control

This block keeps the control and status state that a scalar floating-point datapath needs around each operation. When an operation starts, it clears a per-operation record of raised exceptions. It also decodes the stored 2-bit rounding field into a one-hot rounding select, which holds steady until the next start.

While the operation runs, the datapath reports exceptions on a 5-bit raise vector, and those reports collect in the per-operation record. When the operation ends, the collected exceptions are folded into sticky status bits. A sticky bit can only go from clear to set through this path. If a bit newly goes from clear to set and its enable bit is on, the block emits a one-cycle trap pulse with a cause vector.

Software loads the rounding field, the sticky bits and the enables through one write port and observes them on a status output. A write beats a merge that lands in the same cycle.

Top module: `fpu_status_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, csr_o is 0, op_flags_o is 0, trap_o is 0, trap_cause_o is 0 and rnd_sel_o is 4'b0001.
- R2: An edge with op_start_i high clears op_flags_o to 0, and exceptions raised in that same cycle are dropped.
- R3: An edge with exc_raise_i nonzero and op_start_i low ORs exc_raise_i into op_flags_o. Exception bit positions are: bit 0 inexact, bit 1 divide-by-zero, bit 2 invalid, bit 3 overflow, bit 4 underflow.
- R4: At an op_start_i edge, rnd_sel_o takes the one-hot decode of the stored rounding field: 0 gives 4'b0001 (nearest-even), 1 gives 4'b0010 (toward zero), 2 gives 4'b0100 (toward minus infinity), 3 gives 4'b1000 (toward plus infinity). A write to the field has no effect on rnd_sel_o until the next start.
- R5: An op_end_i edge with nothing raised (op_flags_o and exc_raise_i both 0) leaves csr_o unchanged and raises no trap.
- R6: At an op_end_i edge without a write, each sticky bit is set if the matching bit of op_flags_o | exc_raise_i is 1. A merge never clears a sticky bit.
- R7: When a sticky bit goes from 0 to 1 at a merge and its enable is 1, trap_o is high for exactly the following cycle. trap_cause_o lists every bit that did so.
- R8: A sticky bit that is already 1 never contributes to a trap, even when raised again with its enable on.
- R9: A raised exception whose enable is 0 sets its sticky bit but causes no trap.
- R10: When wr_en_i and op_end_i are high on the same edge, csr_o takes wr_data_i, no merge happens and no trap is raised.
- R11: A write loads csr_o with wr_data_i, laid out as [1:0] rounding field, [6:2] sticky bits, [11:7] enable bits. The exception order within each 5-bit field is the one given in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_start_i | input | 1 | Operation begins this cycle |
| op_end_i | input | 1 | Operation completes this cycle |
| exc_raise_i | input | 5 | Exceptions reported by the datapath this cycle |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 12 | Status register write value |
| csr_o | output | 12 | Rounding field, sticky bits and enables |
| op_flags_o | output | 5 | Exceptions collected during the current operation |
| rnd_sel_o | output | 4 | One-hot rounding select for the datapath |
| trap_o | output | 1 | Trap request pulse |
| trap_cause_o | output | 5 | Exceptions that caused the trap |

## Verification
Every output comes straight from a register. The effect of a start, a raise, an end or a write therefore appears one cycle after the edge that samples it, and a trap pulse lasts only that one cycle. The bench drives inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge, so each check sees the result of exactly one sampled stimulus. A separate check one cycle later confirms that trap_o has returned to 0. For rounding, the bench checks that a field write with no start in between leaves rnd_sel_o unchanged.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int unsigned NUM_EXC = 5;
  localparam int unsigned RND_W   = 2;
  localparam int unsigned NUM_RND = 1 << RND_W;
  localparam int unsigned RND_LSB = 0;
  localparam int unsigned STK_LSB = RND_LSB + RND_W;
  localparam int unsigned ENA_LSB = STK_LSB + NUM_EXC;
  localparam int unsigned CSR_W   = ENA_LSB + NUM_EXC;

  typedef enum int unsigned {
    EXC_INEXACT = 0,
    EXC_DIVZERO = 1,
    EXC_INVALID = 2,
    EXC_OVERFLOW = 3,
    EXC_UNDERFLOW = 4
  } exc_idx_e;

  typedef logic [NUM_EXC-1:0] exc_vec_t;
endpackage

// File: rtl/fpcsr_op_acc.sv
module fpcsr_op_acc
  import fpcsr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  exc_vec_t raise_i,
  output exc_vec_t acc_o,
  output exc_vec_t eff_o
);
  exc_vec_t acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (start_i) acc_q <= '0;
    else              acc_q <= acc_q | raise_i;
  end

  assign acc_o = acc_q;
  // flags seen by an end in this cycle include the current report
  assign eff_o = acc_q | raise_i;
endmodule

// File: rtl/fpcsr_round.sv
module fpcsr_round
  import fpcsr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [RND_W-1:0]   wr_rnd_i,
  input  logic               start_i,
  output logic [RND_W-1:0]   rnd_o,
  output logic [NUM_RND-1:0] sel_o
);
  logic [RND_W-1:0]   rnd_q;
  logic [NUM_RND-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NUM_RND; i++)
      if (rnd_q == RND_W'(i)) sel_d[i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q <= '0;
      sel_q <= NUM_RND'(1);
    end else begin
      if (wr_en_i) rnd_q <= wr_rnd_i;
      if (start_i) sel_q <= sel_d;
    end
  end

  assign rnd_o = rnd_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/fpcsr_sticky.sv
module fpcsr_sticky
  import fpcsr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  exc_vec_t wr_sticky_i,
  input  exc_vec_t wr_enable_i,
  input  logic     end_i,
  input  exc_vec_t eff_i,
  output exc_vec_t sticky_o,
  output exc_vec_t enable_o,
  output logic     trap_o,
  output exc_vec_t cause_o
);
  exc_vec_t sticky_q, enable_q, cause_d, cause_q, set_d;
  logic     trap_q;

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_bit
    assign set_d[g]   = !wr_en_i && end_i && eff_i[g] && !sticky_q[g];
    assign cause_d[g] = set_d[g] && enable_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sticky_q[g] <= 1'b0;
        enable_q[g] <= 1'b0;
      end else if (wr_en_i) begin
        sticky_q[g] <= wr_sticky_i[g];
        enable_q[g] <= wr_enable_i[g];
      end else if (set_d[g]) begin
        sticky_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      trap_q  <= |cause_d;
      cause_q <= cause_d;
    end
  end

  assign sticky_o = sticky_q;
  assign enable_o = enable_q;
  assign trap_o   = trap_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/fpu_status_ctrl.sv
module fpu_status_ctrl
  import fpcsr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_start_i,
  input  logic               op_end_i,
  input  logic [NUM_EXC-1:0] exc_raise_i,
  input  logic               wr_en_i,
  input  logic [CSR_W-1:0]   wr_data_i,
  output logic [CSR_W-1:0]   csr_o,
  output logic [NUM_EXC-1:0] op_flags_o,
  output logic [NUM_RND-1:0] rnd_sel_o,
  output logic               trap_o,
  output logic [NUM_EXC-1:0] trap_cause_o
);
  exc_vec_t         eff, sticky, enable;
  logic [RND_W-1:0] rnd;

  fpcsr_op_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (op_start_i),
    .raise_i (exc_raise_i),
    .acc_o   (op_flags_o),
    .eff_o   (eff)
  );

  fpcsr_round u_rnd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_rnd_i (wr_data_i[RND_LSB +: RND_W]),
    .start_i  (op_start_i),
    .rnd_o    (rnd),
    .sel_o    (rnd_sel_o)
  );

  fpcsr_sticky u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sticky_i (wr_data_i[STK_LSB +: NUM_EXC]),
    .wr_enable_i (wr_data_i[ENA_LSB +: NUM_EXC]),
    .end_i       (op_end_i),
    .eff_i       (eff),
    .sticky_o    (sticky),
    .enable_o    (enable),
    .trap_o      (trap_o),
    .cause_o     (trap_cause_o)
  );

  assign csr_o = {enable, sticky, rnd};
endmodule

// File: rtl/fpu_status_ctrl_chk.sv
module fpu_status_ctrl_chk
  import fpcsr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_start_i,
  input logic               op_end_i,
  input logic [NUM_EXC-1:0] exc_raise_i,
  input logic               wr_en_i,
  input logic [CSR_W-1:0]   wr_data_i,
  input logic [CSR_W-1:0]   csr_o,
  input logic [NUM_EXC-1:0] op_flags_o,
  input logic [NUM_RND-1:0] rnd_sel_o,
  input logic               trap_o,
  input logic [NUM_EXC-1:0] trap_cause_o
);
  exc_vec_t stk, ena;
  assign stk = csr_o[STK_LSB +: NUM_EXC];
  assign ena = csr_o[ENA_LSB +: NUM_EXC];

  p_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_i |=> op_flags_o == '0);

  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rnd_sel_o) == 1);

  p_idle_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_end_i && !wr_en_i && exc_raise_i == '0 && op_flags_o == '0) |=> ($stable(csr_o) && !trap_o));

  p_sticky_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (($past(stk) & ~stk) == '0));

  p_trap_after_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($past(op_end_i) && trap_cause_o != '0));

  p_no_retrigger_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (($past(stk) & trap_cause_o) == '0));

  p_cause_enabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ((trap_cause_o & ~$past(ena)) == '0));

  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (csr_o == $past(wr_data_i) && !trap_o));

  always_comb begin
    if (!rst_ni) p_reset_state_r1: assert (trap_o == 1'b0 || $isunknown(trap_o));
  end
endmodule

bind fpu_status_ctrl fpu_status_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_start_i   (op_start_i),
  .op_end_i     (op_end_i),
  .exc_raise_i  (exc_raise_i),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .csr_o        (csr_o),
  .op_flags_o   (op_flags_o),
  .rnd_sel_o    (rnd_sel_o),
  .trap_o       (trap_o),
  .trap_cause_o (trap_cause_o)
);

// File: tb/fpu_status_ctrl_bench.sv
`timescale 1ns/1ps
module fpu_status_ctrl_bench;
  import fpcsr_pkg::*;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               op_start_i = 1'b0;
  logic               op_end_i = 1'b0;
  logic [NUM_EXC-1:0] exc_raise_i = '0;
  logic               wr_en_i = 1'b0;
  logic [CSR_W-1:0]   wr_data_i = '0;
  logic [CSR_W-1:0]   csr_o;
  logic [NUM_EXC-1:0] op_flags_o;
  logic [NUM_RND-1:0] rnd_sel_o;
  logic               trap_o;
  logic [NUM_EXC-1:0] trap_cause_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fpu_status_ctrl u_fpu_status_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_start_i(op_start_i), .op_end_i(op_end_i),
    .exc_raise_i(exc_raise_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .csr_o(csr_o), .op_flags_o(op_flags_o), .rnd_sel_o(rnd_sel_o),
    .trap_o(trap_o), .trap_cause_o(trap_cause_o)
  );

  function automatic logic [CSR_W-1:0] mk(input logic [4:0] en, input logic [4:0] st, input logic [1:0] rm);
    return {en, st, rm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    op_start_i = 1'b0; op_end_i = 1'b0; exc_raise_i = '0; wr_en_i = 1'b0;
  endtask

  task automatic do_write(input logic [CSR_W-1:0] v);
    wr_en_i = 1'b1; wr_data_i = v;
    step();
  endtask

  task automatic t_reset();
    chk("R1 csr", csr_o, 0);
    chk("R1 flags", op_flags_o, 0);
    chk("R1 sel", rnd_sel_o, 4'b0001);
    chk("R1 trap", {trap_o, trap_cause_o}, 0);
  endtask

  task automatic t_write();
    do_write(mk(5'b10101, 5'b01010, 2'd2));
    chk("R11 write layout", csr_o, 12'b10101_01010_10);
    do_write('0);
    chk("R11 write zero", csr_o, 0);
  endtask

  task automatic t_round();
    for (int m = 0; m < 4; m++) begin
      do_write(mk(5'b0, 5'b0, 2'(m)));
      op_start_i = 1'b1; step();
      chk("R4 decode", rnd_sel_o, 32'(1 << m));
    end
    do_write(mk(5'b0, 5'b0, 2'd1));
    chk("R4 no start hold", rnd_sel_o, 4'b1000);
    op_start_i = 1'b1; step();
    chk("R4 next start", rnd_sel_o, 4'b0010);
  endtask

  task automatic t_accum();
    op_start_i = 1'b1; exc_raise_i = 5'b11111; step();
    chk("R2 start drops same-cycle raise", op_flags_o, 0);
    exc_raise_i = 5'b00001; step();
    exc_raise_i = 5'b00100; step();
    chk("R3 accumulate", op_flags_o, 5'b00101);
    op_start_i = 1'b1; step();
    chk("R2 start clears", op_flags_o, 0);
  endtask

  task automatic t_idle_end();
    do_write(mk(5'b11111, 5'b00110, 2'd3));
    op_start_i = 1'b1; step();
    op_end_i = 1'b1; step();
    chk("R5 csr unchanged", csr_o, mk(5'b11111, 5'b00110, 2'd3));
    chk("R5 no trap", trap_o, 0);
  endtask

  task automatic t_trap();
    do_write(mk(5'b11111, 5'b0, 2'd0));
    op_start_i = 1'b1; step();
    exc_raise_i = 5'b00001; step();
    op_end_i = 1'b1; exc_raise_i = 5'b01000; step();
    chk("R6 sticky set", csr_o, mk(5'b11111, 5'b01001, 2'd0));
    chk("R7 trap", trap_o, 1);
    chk("R7 cause", trap_cause_o, 5'b01001);
    step();
    chk("R7 one-cycle pulse", trap_o, 0);
  endtask

  task automatic t_retrigger();
    op_start_i = 1'b1; step();
    op_end_i = 1'b1; exc_raise_i = 5'b01011; step();
    chk("R8 only new bit", trap_cause_o, 5'b00010);
    chk("R6 sticky merged", csr_o, mk(5'b11111, 5'b01011, 2'd0));
    op_start_i = 1'b1; step();
    op_end_i = 1'b1; exc_raise_i = 5'b01011; step();
    chk("R8 no retrigger", {trap_o, trap_cause_o}, 0);
    chk("R6 sticky kept", csr_o, mk(5'b11111, 5'b01011, 2'd0));
  endtask

  task automatic t_disabled();
    do_write(mk(5'b01111, 5'b0, 2'd0));
    op_start_i = 1'b1; step();
    op_end_i = 1'b1; exc_raise_i = 5'b10001; step();
    chk("R9 sticky set", csr_o, mk(5'b01111, 5'b10001, 2'd0));
    chk("R9 cause only enabled", trap_cause_o, 5'b00001);
    do_write(mk(5'b00000, 5'b0, 2'd0));
    op_start_i = 1'b1; step();
    op_end_i = 1'b1; exc_raise_i = 5'b00100; step();
    chk("R9 no trap when disabled", trap_o, 0);
    chk("R9 sticky still set", csr_o, mk(5'b0, 5'b00100, 2'd0));
  endtask

  task automatic t_write_prio();
    do_write(mk(5'b11111, 5'b0, 2'd0));
    op_start_i = 1'b1; step();
    wr_en_i = 1'b1; wr_data_i = mk(5'b11110, 5'b00000, 2'd1);
    op_end_i = 1'b1; exc_raise_i = 5'b11111; step();
    chk("R10 write wins", csr_o, mk(5'b11110, 5'b0, 2'd1));
    chk("R10 no trap", trap_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_write();
    t_round();
    t_accum();
    t_idle_end();
    t_trap();
    t_retrigger();
    t_disabled();
    t_write_prio();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule